// File: doc/BRIEF.md
# Audio Capture Receive FIFO

This block buffers digitized audio samples coming from a stereo capture path and hands them to a bus master, normally a DMA engine. On each sample tick, when capture is enabled, it stores a left and a right 24-bit sample. In mono mode it stores only the left sample. Stored samples come out in arrival order through a data port on a simple register bus.

Each sample is formatted as it is read. It is given as a 16-bit or a 24-bit value, either sign-extended in the low bits of the 32-bit word or placed in its upper bits with the rest zero. A request line asks the DMA engine for service once the number of stored entries passes a programmable trigger level. The engine then drains the FIFO in short bursts of up to four words.

Software can empty the FIFO with a self-clearing flush bit. A sticky flag records frames that were lost because there was no room. A running counter gives the total number of entries stored.

Top module: `acapRxFifo`

## Requirements
- R1: Registers are at fixed byte offsets: control 0x1c, status 0x20, data 0x24, count 0x34. Any other offset reads 0. A read returns its value on busRdata at the clock edge that samples busRd. The control word reads back the written value of every field except the flush bit, which reads 0.
- R2: Control bit 28 enables capture. While it is clear, sample ticks store nothing.
- R3: In stereo mode (control bit 7 clear), each accepted tick stores the left sample and then the right sample. Data port reads return entries oldest first.
- R4: In mono mode (control bit 7 set), each accepted tick stores only the left sample, which is one entry.
- R5: Formatting applies at read time. Control bit 6 set selects a 24-bit sample; clear selects the upper 16 bits of the sample. Control bit 24 set places the selected bits at the top of the word with the low bits zero. Clear right-aligns them with sign extension.
- R6: Reading the data port while the FIFO is empty returns 0 and leaves the fill level unchanged.
- R7: dmaReq is high exactly when control bit 4 is set and the fill level is greater than the 4-bit trigger field in control bits 11:8. It follows the level in the same cycle the level changes.
- R8: A tick whose whole frame does not fit in the free space is discarded entirely. That means two entries in stereo, one in mono. The fill level stays the same and status bit 8 (overflow) is set and stays set. Free space is judged before a read in the same cycle.
- R9: Writing control bit 0 as 1 empties the FIFO and clears the overflow flag in that cycle. It takes priority over a tick in the same cycle, and the bit reads back as 0.
- R10: The count register adds the number of entries stored by each accepted tick. A flush does not clear it.
- R11: Status bits 5:0 give the fill level, from 0 to the depth of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe; a data read pops one entry |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| sampleTick | input | 1 | One-cycle strobe marking a new sample frame |
| sampleLeft | input | 24 | Left sample |
| sampleRight | input | 24 | Right sample |
| dmaReq | output | 1 | DMA service request |

## Verification
A tick or a flush changes the fill level, the overflow flag, the count and dmaReq at the next rising edge, so all of them can be observed one cycle after the stimulus. A register read presents its value on busRdata at the edge that samples busRd. Read data is therefore valid one cycle after the strobe and holds until the next read. The bench drives inputs and samples outputs on falling edges, so each check lands half a cycle after the edge that produced its value. Expected values come from a queue model that applies the same one-cycle rules.

// File: rtl/acapPkg.sv
package acapPkg;
  localparam logic [7:0] OFS_CTRL = 8'h1c;
  localparam logic [7:0] OFS_STAT = 8'h20;
  localparam logic [7:0] OFS_DATA = 8'h24;
  localparam logic [7:0] OFS_CNT  = 8'h34;

  localparam int BIT_FLUSH = 0;
  localparam int BIT_DMAEN = 4;
  localparam int BIT_W24   = 6;
  localparam int BIT_MONO  = 7;
  localparam int BIT_TRIG  = 8;
  localparam int BIT_MSB   = 24;
  localparam int BIT_CAPEN = 28;
  localparam int BIT_OVF   = 8;

  typedef struct packed {
    logic       capEn;
    logic       msbAlign;
    logic [3:0] trig;
    logic       mono;
    logic       width24;
    logic       dmaEn;
  } ctlFields_t;

  typedef struct packed {
    logic flush;
    logic pop;
    logic push;
    logic mono;
    logic width24;
    logic msbAlign;
  } strobe_t;
endpackage

// File: rtl/acapCtrl.sv
module acapCtrl
  import acapPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [31:0]       busWdata,
  input  logic              sampleTick,
  input  logic [LVL_W-1:0]  level,
  input  logic              overflow,
  input  logic [CNT_W-1:0]  count,
  input  logic [31:0]       headWord,
  input  logic              empty,
  output ctlFields_t        ctl,
  output strobe_t           stb,
  output logic [31:0]       busRdata,
  output logic              dmaReq
);
  logic        ctrlHit;
  logic [31:0] ctrlWord;
  logic [31:0] statWord;
  logic [31:0] rdMux;
  logic        unusedWdata;

  assign ctrlHit = (busAddr == ADDR_W'(OFS_CTRL));
  assign unusedWdata = ^{busWdata[31:29], busWdata[27:25], busWdata[23:12],
                         busWdata[5], busWdata[3:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl <= '0;
    end else if (busWr && ctrlHit) begin
      ctl.capEn    <= busWdata[BIT_CAPEN];
      ctl.msbAlign <= busWdata[BIT_MSB];
      ctl.trig     <= busWdata[BIT_TRIG +: 4];
      ctl.mono     <= busWdata[BIT_MONO];
      ctl.width24  <= busWdata[BIT_W24];
      ctl.dmaEn    <= busWdata[BIT_DMAEN];
    end
  end

  always_comb begin
    stb          = '0;
    stb.flush    = busWr && ctrlHit && busWdata[BIT_FLUSH];
    stb.pop      = busRd && (busAddr == ADDR_W'(OFS_DATA)) && !empty;
    stb.push     = sampleTick && ctl.capEn;
    stb.mono     = ctl.mono;
    stb.width24  = ctl.width24;
    stb.msbAlign = ctl.msbAlign;
  end

  always_comb begin
    ctrlWord                 = '0;
    ctrlWord[BIT_CAPEN]      = ctl.capEn;
    ctrlWord[BIT_MSB]        = ctl.msbAlign;
    ctrlWord[BIT_TRIG +: 4]  = ctl.trig;
    ctrlWord[BIT_MONO]       = ctl.mono;
    ctrlWord[BIT_W24]        = ctl.width24;
    ctrlWord[BIT_DMAEN]      = ctl.dmaEn;
    statWord                 = '0;
    statWord[LVL_W-1:0]      = level;
    statWord[BIT_OVF]        = overflow;
  end

  always_comb begin
    rdMux = '0;
    if (busAddr == ADDR_W'(OFS_CTRL))      rdMux = ctrlWord;
    else if (busAddr == ADDR_W'(OFS_STAT)) rdMux = statWord;
    else if (busAddr == ADDR_W'(OFS_DATA)) rdMux = empty ? 32'h0 : headWord;
    else if (busAddr == ADDR_W'(OFS_CNT))  rdMux = 32'(count);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else if (busRd) busRdata <= rdMux;
  end

  assign dmaReq = ctl.dmaEn && (level > LVL_W'(ctl.trig));
endmodule

// File: rtl/acapDatapath.sv
module acapDatapath
  import acapPkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 32,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  output logic [LVL_W-1:0]    level,
  output logic                overflow,
  output logic [CNT_W-1:0]    count,
  output logic [31:0]         headWord,
  output logic                empty
);
  localparam int LANES = 2;
  localparam int PAD_W = 32 - SAMPLE_W;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic [LVL_W-1:0]    frameN;
  logic                fits, accept, drop;
  logic [SAMPLE_W-1:0] lane [LANES];
  logic [SAMPLE_W-1:0] head;
  logic [15:0]         head16;

  assign lane[0] = sampleLeft;
  assign lane[1] = sampleRight;

  assign frameN = stb.mono ? LVL_W'(1) : LVL_W'(2);
  assign fits   = ({1'b0, level} + {1'b0, frameN}) <= (LVL_W + 1)'(DEPTH);
  assign accept = stb.push && fits && !stb.flush;
  assign drop   = stb.push && !fits && !stb.flush;
  assign empty  = (level == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      overflow <= 1'b0;
      count    <= '0;
    end else if (stb.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) begin
        wrPtr <= wrPtr + PTR_W'(frameN);
        count <= count + CNT_W'(frameN);
      end
      if (stb.pop) rdPtr <= rdPtr + PTR_W'(1);
      level <= level + (accept ? frameN : '0) - (stb.pop ? LVL_W'(1) : '0);
      if (drop) overflow <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      always_ff @(posedge clk) begin
        if (accept && (g == 0 || !stb.mono))
          mem[wrPtr + PTR_W'(g)] <= lane[g];
      end
    end
  endgenerate

  assign head   = mem[rdPtr];
  assign head16 = head[SAMPLE_W-1 -: 16];

  always_comb begin
    if (stb.width24)
      headWord = stb.msbAlign ? {head, {PAD_W{1'b0}}}
                              : {{PAD_W{head[SAMPLE_W-1]}}, head};
    else
      headWord = stb.msbAlign ? {head16, 16'h0}
                              : {{16{head16[15]}}, head16};
  end
endmodule

// File: rtl/acapRxFifo.sv
module acapRxFifo
  import acapPkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 32,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic                sampleTick,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  output logic                dmaReq
);
  ctlFields_t       ctl;
  strobe_t          stb;
  logic [LVL_W-1:0] level;
  logic             overflow;
  logic [CNT_W-1:0] count;
  logic [31:0]      headWord;
  logic             empty;

  acapCtrl #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .sampleTick(sampleTick), .level(level),
    .overflow(overflow), .count(count), .headWord(headWord), .empty(empty),
    .ctl(ctl), .stb(stb), .busRdata(busRdata), .dmaReq(dmaReq)
  );

  acapDatapath #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sampleLeft(sampleLeft),
    .sampleRight(sampleRight), .level(level), .overflow(overflow),
    .count(count), .headWord(headWord), .empty(empty)
  );
endmodule

// File: rtl/acapRxFifoChk.sv
module acapRxFifoChk
  import acapPkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              sampleTick,
  input logic              dmaReq,
  input logic [LVL_W-1:0]  level,
  input logic              overflow,
  input ctlFields_t        ctl
);
  logic flushWr;
  logic unusedChk;
  assign flushWr   = busWr && (busAddr == ADDR_W'(OFS_CTRL)) && busWdata[0];
  assign unusedChk = ^{busWdata, ctl};

  // R11: fill level never exceeds the depth
  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  // R9: flush empties the FIFO and clears overflow
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flushWr |=> (level == '0) && !overflow);

  // R8: overflow flag is sticky until a flush
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !flushWr) |=> overflow);

  // R2: with capture off and no bus traffic the level holds
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.capEn && !busRd && !busWr) |=> $stable(level));

  // R6: empty data read returns zero
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(OFS_DATA) && level == '0) |=> busRdata == 32'h0);

  // R7: no request with an empty FIFO
  a_r7_no_req_empty: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0) |-> !dmaReq);

  // R4: a mono tick with room adds exactly one entry
  a_r4_mono_single: assert property (@(posedge clk) disable iff (!rstN)
    (!busWr && !busRd && ctl.mono && ctl.capEn && sampleTick && level < LVL_W'(DEPTH))
    |=> level == LVL_W'($past(level) + 1'b1));
endmodule

bind acapRxFifo acapRxFifoChk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .busRdata(busRdata), .sampleTick(sampleTick),
  .dmaReq(dmaReq), .level(level), .overflow(overflow), .ctl(ctl)
);

// File: tb/sim_acapRxFifo.sv
module sim_acapRxFifo;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sampleTick = 1'b0;
  logic [23:0] sampleLeft = '0, sampleRight = '0;
  logic        dmaReq;

  int nChecks = 0, nErrors = 0;
  bit done = 0;

  logic [23:0] mq[$];
  bit mOvf = 0;
  int unsigned mCnt = 0;
  bit capEn = 0, mono = 0, w24 = 0, msb = 0, dmaEn = 0;
  int trig = 0;

  always #10 clk = ~clk;

  acapRxFifo u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .sampleTick(sampleTick),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight), .dmaReq(dmaReq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fmt(logic [23:0] s);
    if (w24) return msb ? {s, 8'h0} : {{8{s[23]}}, s};
    return msb ? {s[23:8], 16'h0} : {{16{s[23]}}, s[23:8]};
  endfunction

  function automatic logic [31:0] ctlWord(bit flush);
    logic [31:0] w = '0;
    w[28] = capEn; w[24] = msb; w[11:8] = 4'(trig);
    w[7] = mono; w[6] = w24; w[4] = dmaEn; w[0] = flush;
    return w;
  endfunction

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic setCtl(bit flush);
    busWrite(8'h1c, ctlWord(flush));
    if (flush) begin mq.delete(); mOvf = 0; end
  endtask

  task automatic tick(logic [23:0] l, logic [23:0] r);
    int n = mono ? 1 : 2;
    sampleLeft = l; sampleRight = r; sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
    if (capEn) begin
      if (mq.size() + n <= 32) begin
        mq.push_back(l);
        if (!mono) mq.push_back(r);
        mCnt += n;
      end else mOvf = 1;
    end
  endtask

  task automatic checkReq(string tag);
    chk(tag, 32'(dmaReq), 32'(dmaEn && (mq.size() > trig)));
  endtask

  task automatic checkStat(string tag);
    logic [31:0] d;
    busRead(8'h20, d);
    chk(tag, d, (32'(mOvf) << 8) | 32'(mq.size()));
  endtask

  task automatic readData(string tag);
    logic [31:0] d, e;
    e = (mq.size() == 0) ? 32'h0 : fmt(mq.pop_front());
    busRead(8'h24, d);
    chk(tag, d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values and map
    busRead(8'h1c, d); chk("R1 ctrl reset", d, 0);
    busRead(8'h34, d); chk("R1 count reset", d, 0);
    busRead(8'h10, d); chk("R1 unmapped", d, 0);
    checkStat("R11 status reset");
    checkReq("R7 reset req");
    readData("R6 empty at reset");

    // R2 capture disabled
    tick(24'h111111, 24'h222222); tick(24'h333333, 24'h444444);
    checkStat("R2 ticks ignored");

    // R3 stereo order, R5 24-bit top-aligned
    capEn = 1; w24 = 1; msb = 1; setCtl(1);
    busRead(8'h1c, d); chk("R1 ctrl readback", d, ctlWord(0));
    for (int i = 0; i < 3; i++) tick(24'h100000 + 24'(i), 24'h800000 + 24'(i));
    checkStat("R3 stereo level");
    for (int i = 0; i < 6; i++) readData("R3 stereo order");

    // R4 mono
    mono = 1; setCtl(0);
    tick(24'hABCDEF, 24'h555555); tick(24'h123456, 24'h666666);
    checkStat("R4 mono level");
    readData("R4 mono left");
    readData("R4 mono left");

    // R5 all formats on a negative sample
    for (int m = 0; m < 4; m++) begin
      w24 = m[0]; msb = m[1]; setCtl(0);
      tick(24'h9ABCDE, 24'h0);
      readData("R5 format");
    end

    // R7 trigger
    mono = 0; w24 = 1; msb = 0; trig = 7; dmaEn = 1; setCtl(1);
    for (int i = 0; i < 4; i++) begin
      tick(24'(i * 3), 24'(i * 5));
      checkReq("R7 req vs level");
    end
    for (int i = 0; i < 4; i++) begin
      readData("R7 burst read");
      checkReq("R7 req after burst read");
    end
    dmaEn = 0; setCtl(0); tick(24'h7, 24'h8); checkReq("R7 req disabled");

    // R8 overflow on full, R9 flush
    setCtl(1);
    for (int i = 0; i < 16; i++) tick(24'(i), 24'(i + 100));
    checkStat("R11 full level");
    tick(24'hFFFFFF, 24'hFFFFFF);
    checkStat("R8 overflow full");
    readData("R8 first kept");
    checkStat("R8 sticky after read");
    setCtl(1);
    checkStat("R9 flush clears");
    busRead(8'h34, d); chk("R10 count kept over flush", d, mCnt);

    // R8 stereo frame with one free slot
    mono = 1; setCtl(0);
    for (int i = 0; i < 31; i++) tick(24'(i + 7), 24'h0);
    mono = 0; setCtl(0);
    tick(24'hAAAAAA, 24'hBBBBBB);
    checkStat("R8 partial frame dropped");
    mono = 1; setCtl(0);
    tick(24'hCCCCCC, 24'h0);
    checkStat("R8 mono fits last slot");
    while (mq.size() > 0) readData("R3 drain");
    readData("R6 empty read zero");
    checkStat("R6 level unchanged");
    busRead(8'h34, d); chk("R10 count", d, mCnt);

    // random mix
    setCtl(1);
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) tick(24'($urandom), 24'($urandom));
      else if (op < 7) readData("R3 random read");
      else if (op == 7) checkStat("R11 random status");
      else if (op == 8) begin
        busRead(8'h34, d); chk("R10 random count", d, mCnt);
      end else begin
        capEn = ($urandom_range(0, 5) != 0); mono = 1'($urandom);
        w24 = 1'($urandom); msb = 1'($urandom); dmaEn = 1'($urandom);
        trig = $urandom_range(0, 15);
        setCtl($urandom_range(0, 5) == 0);
      end
      checkReq("R7 random req");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule